// File: doc/BRIEF.md
# Device Error Classification and Signaling Unit

This unit sits beside a device function's error detectors. The detectors offer one error event at a time. Each event carries a one-hot error status vector, a correctable/uncorrectable class flag, an advisory flag and a 16-bit requester ID. The unit first validates the event. It then decides the severity of the event and records it in its correctable and uncorrectable status registers and in a small set of device-status "detected" flags. From the mask and severity registers and the reporting enables, it decides whether an error message is sent upstream and whether the header-capture logic must log a header.

The event input is a valid/ready stream. An event is consumed on any cycle where `evt_valid` and `evt_ready` are both high. `evt_ready` is low only in the single cycle in which the unit handles an internally generated header-log-overflow error. A producer must hold its event stable until it is consumed. The message and header-log outputs are single-cycle pulses and have no back-pressure. The header store answers a `hdr_req` pulse in the same cycle on `hdr_overflow`. Configuration writes use a plain write strobe with a register select.

Top module: `err_signal_unit`

## Requirements
- R1: The status vector is ANDed with the supported set for its class. The correctable set is bits {0,6,7,8,12,13,14,15}. The uncorrectable set is bits {4,5} and bits 12 through 25. If the result is not exactly one bit, the event is consumed and discarded: no status, device-status, message or header-request change.
- R2: The uncorrectable severity register resets to fatal for bits 4, 5, 13, 17, 18 and 22, and to non-fatal for every other bit. An uncorrectable error is fatal when its bit is set in this register, and writing the register overrides the default.
- R3: A correctable error always sets its correctable status bit and the correctable-detected flag (device-status bit 0). When that bit is set in the correctable mask, no message is sent.
- R4: An unmasked correctable error sends a message only when correctable reporting is enabled. An advisory unsupported request (uncorrectable bit 20) also needs unsupported-request reporting enabled.
- R5: An uncorrectable error (not on the advisory path) always sets its uncorrectable status bit. It sets the fatal-detected flag (bit 2) or the non-fatal-detected flag (bit 1), and bit 20 also sets the unsupported-request-detected flag (bit 3). If the bit is masked, no header is requested and no message is sent. Otherwise a header is requested.
- R6: An unmasked fatal error sends a message when the system-error enable or fatal reporting is on. A non-fatal error sends a message when the system-error enable or non-fatal reporting is on. An unsupported request is dropped when unsupported-request reporting and the system-error enable are both off.
- R7: A non-fatal uncorrectable error with the advisory flag sets correctable bit 13 and its own uncorrectable bit, and raises the correctable-detected flag. If correctable bit 13 is masked, nothing else happens. Otherwise a header is requested only if its uncorrectable bit is unmasked, and the message follows R4 with severity correctable.
- R8: When `hdr_overflow` is high during a `hdr_req` pulse, the unit holds `evt_ready` low and `busy` high for the next cycle. In that cycle it handles a correctable error on bit 15 with the source ID of the overflowing event. `hdr_overflow` has no effect at any other time.
- R9: `msg_valid` and `hdr_req` pulse for exactly one cycle, in the cycle after the event is handled. `msg_sev` is 0 for correctable, 1 for non-fatal and 2 for fatal.
- R10: The register select values are 0 uncorrectable status, 1 uncorrectable mask, 2 uncorrectable severity, 3 correctable status, 4 correctable mask and 5 device status. A write to a status register clears the bits that are written as one, and a write to any other register loads it. Without such a write, status bits never clear. The masks reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Error event offered |
| evt_ready | output | 1 | Unit can take an event this cycle |
| evt_status | input | 32 | One-hot error bit |
| evt_corr | input | 1 | Event is of the correctable class |
| evt_advisory | input | 1 | Event may be handled as advisory non-fatal |
| evt_src | input | 16 | Requester ID of the event |
| reg_wr | input | 1 | Configuration write strobe |
| reg_sel | input | 3 | Register select (see R10) |
| reg_wdata | input | 32 | Write data |
| ctl_cor_en | input | 1 | Correctable reporting enable |
| ctl_nonfatal_en | input | 1 | Non-fatal reporting enable |
| ctl_fatal_en | input | 1 | Fatal reporting enable |
| ctl_ur_en | input | 1 | Unsupported-request reporting enable |
| cmd_serr_en | input | 1 | System-error enable |
| msg_valid | output | 1 | Error message pulse |
| msg_sev | output | 2 | Message severity code |
| msg_src | output | 16 | Message requester ID |
| hdr_req | output | 1 | Header must be logged |
| hdr_overflow | input | 1 | Header store full, answer to hdr_req |
| busy | output | 1 | Overflow follow-on in progress |
| unc_status | output | 32 | Uncorrectable status register |
| cor_status | output | 32 | Correctable status register |
| dev_status | output | 4 | Detected flags {UR, fatal, non-fatal, correctable} |

## Verification
A wrong classification shows at the ports one cycle after the event is consumed. It appears as a wrong status bit, a wrong detected flag, a missing or extra `msg_valid` pulse, or a wrong `msg_sev`. Because the status registers are sticky, a corrupted bit persists and is caught by every later comparison until it is cleared. A lost or spurious overflow follow-on shows two cycles after the header request, as an unexpected `busy` level or a missing correctable message on bit 15. Random events with random masks, severities and enables are mixed with directed cases for rejection, severity override, advisory handling, unsupported-request drops and overflow.

// File: rtl/err_signal_pkg.sv
package err_signal_pkg;
  localparam int STW = 32;
  localparam int DEVW = 4;

  localparam logic [STW-1:0] COR_SUPPORTED     = 32'h0000_F1C1;
  localparam logic [STW-1:0] UNC_SUPPORTED     = 32'h03FF_F030;
  localparam logic [STW-1:0] UNC_FATAL_DEFAULT = 32'h0046_2030;

  localparam int UR_BIT  = 20;
  localparam int ADV_BIT = 13;
  localparam int HLO_BIT = 15;

  localparam int DEV_COR = 0;
  localparam int DEV_NF  = 1;
  localparam int DEV_FAT = 2;
  localparam int DEV_UR  = 3;

  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  typedef enum logic [2:0] {
    SEL_UNC_STAT = 3'd0,
    SEL_UNC_MASK = 3'd1,
    SEL_UNC_SEV  = 3'd2,
    SEL_COR_STAT = 3'd3,
    SEL_COR_MASK = 3'd4,
    SEL_DEV_STAT = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic            reject;
    logic [STW-1:0]  unc_set;
    logic [STW-1:0]  cor_set;
    logic [DEVW-1:0] dev_set;
    logic            hdr;
    logic            msg;
    sev_e            sev;
  } verdict_t;
endpackage

// File: rtl/err_classify.sv
module err_classify
  import err_signal_pkg::*;
(
  input  logic [STW-1:0] ev_status,
  input  logic           ev_corr,
  input  logic           ev_adv,
  input  logic [STW-1:0] unc_mask,
  input  logic [STW-1:0] unc_sev,
  input  logic [STW-1:0] cor_mask,
  input  logic           cor_en,
  input  logic           nonfatal_en,
  input  logic           fatal_en,
  input  logic           ur_en,
  input  logic           serr_en,
  output verdict_t       verdict
);
  logic [STW-1:0] bitv;
  logic [STW-1:0] cbit;
  logic           onehot, is_ur, fatal, adv_path;

  always_comb begin
    bitv     = ev_status & (ev_corr ? COR_SUPPORTED : UNC_SUPPORTED);
    onehot   = (bitv != '0) && ((bitv & (bitv - 32'd1)) == '0);
    is_ur    = !ev_corr && bitv[UR_BIT];
    fatal    = !ev_corr && ((bitv & unc_sev) != '0);
    adv_path = !ev_corr && !fatal && ev_adv;
    cbit     = ev_corr ? bitv : (32'h1 << ADV_BIT);

    verdict        = '0;
    verdict.sev    = SEV_COR;
    verdict.reject = !onehot;
    if (onehot) begin
      if (ev_corr || adv_path) begin
        verdict.cor_set         = cbit;
        verdict.dev_set[DEV_COR] = 1'b1;
        verdict.dev_set[DEV_UR]  = is_ur;
        if (adv_path) verdict.unc_set = bitv;
        if ((cbit & cor_mask) == '0) begin
          verdict.hdr = adv_path && ((bitv & unc_mask) == '0);
          verdict.msg = cor_en && !(is_ur && !ur_en);
        end
      end else begin
        verdict.unc_set = bitv;
        if (fatal) verdict.dev_set[DEV_FAT] = 1'b1;
        else       verdict.dev_set[DEV_NF]  = 1'b1;
        verdict.dev_set[DEV_UR] = is_ur;
        if ((bitv & unc_mask) == '0) begin
          verdict.hdr = 1'b1;
          verdict.sev = fatal ? SEV_FATAL : SEV_NONFATAL;
          verdict.msg = !(is_ur && !ur_en && !serr_en) &&
                        (serr_en || (fatal ? fatal_en : nonfatal_en));
        end
      end
    end
  end
endmodule

// File: rtl/err_regs.sv
module err_regs
  import err_signal_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [2:0]      sel,
  input  logic [STW-1:0]  wdata,
  input  logic [STW-1:0]  unc_set,
  input  logic [STW-1:0]  cor_set,
  input  logic [DEVW-1:0] dev_set,
  output logic [STW-1:0]  unc_status,
  output logic [STW-1:0]  cor_status,
  output logic [DEVW-1:0] dev_status,
  output logic [STW-1:0]  unc_mask,
  output logic [STW-1:0]  unc_sev,
  output logic [STW-1:0]  cor_mask
);
  logic [STW-1:0]  unc_clr, cor_clr;
  logic [DEVW-1:0] dev_clr;

  always_comb begin
    unc_clr = (wr && sel == SEL_UNC_STAT) ? wdata : '0;
    cor_clr = (wr && sel == SEL_COR_STAT) ? wdata : '0;
    dev_clr = (wr && sel == SEL_DEV_STAT) ? wdata[DEVW-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unc_status <= '0;
      cor_status <= '0;
      dev_status <= '0;
      unc_mask   <= '0;
      cor_mask   <= '0;
      unc_sev    <= UNC_FATAL_DEFAULT;
    end else begin
      unc_status <= (unc_status & ~unc_clr) | unc_set;
      cor_status <= (cor_status & ~cor_clr) | cor_set;
      dev_status <= (dev_status & ~dev_clr) | dev_set;
      if (wr && sel == SEL_UNC_MASK) unc_mask <= wdata;
      if (wr && sel == SEL_UNC_SEV)  unc_sev  <= wdata;
      if (wr && sel == SEL_COR_MASK) cor_mask <= wdata;
    end
  end

  assert_unc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_UNC_STAT) |=> ((unc_status & $past(unc_status)) == $past(unc_status)));
  assert_cor_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_COR_STAT) |=> ((cor_status & $past(cor_status)) == $past(cor_status)));
endmodule

// File: rtl/err_signal_unit.sv
module err_signal_unit
  import err_signal_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  output logic             evt_ready,
  input  logic [31:0]      evt_status,
  input  logic             evt_corr,
  input  logic             evt_advisory,
  input  logic [SRC_W-1:0] evt_src,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [31:0]      reg_wdata,
  input  logic             ctl_cor_en,
  input  logic             ctl_nonfatal_en,
  input  logic             ctl_fatal_en,
  input  logic             ctl_ur_en,
  input  logic             cmd_serr_en,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [SRC_W-1:0] msg_src,
  output logic             hdr_req,
  input  logic             hdr_overflow,
  output logic             busy,
  output logic [31:0]      unc_status,
  output logic [31:0]      cor_status,
  output logic [3:0]       dev_status
);
  logic             ovf_pend;
  logic [SRC_W-1:0] ovf_src, last_src;
  logic             accept, apply, take;
  logic [STW-1:0]   cls_status, unc_mask, unc_sev, cor_mask;
  logic             cls_corr, cls_adv;
  verdict_t         v;

  assign busy      = ovf_pend;
  assign evt_ready = !ovf_pend;
  assign accept    = evt_valid && evt_ready;
  assign apply     = accept || ovf_pend;
  assign take      = apply && !v.reject;

  always_comb begin
    if (ovf_pend) begin
      cls_status = 32'h1 << HLO_BIT;
      cls_corr   = 1'b1;
      cls_adv    = 1'b0;
    end else begin
      cls_status = evt_status;
      cls_corr   = evt_corr;
      cls_adv    = evt_advisory;
    end
  end

  err_classify u_cls (
    .ev_status  (cls_status),
    .ev_corr    (cls_corr),
    .ev_adv     (cls_adv),
    .unc_mask   (unc_mask),
    .unc_sev    (unc_sev),
    .cor_mask   (cor_mask),
    .cor_en     (ctl_cor_en),
    .nonfatal_en(ctl_nonfatal_en),
    .fatal_en   (ctl_fatal_en),
    .ur_en      (ctl_ur_en),
    .serr_en    (cmd_serr_en),
    .verdict    (v)
  );

  err_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .unc_set   (take ? v.unc_set : '0),
    .cor_set   (take ? v.cor_set : '0),
    .dev_set   (take ? v.dev_set : '0),
    .unc_status(unc_status),
    .cor_status(cor_status),
    .dev_status(dev_status),
    .unc_mask  (unc_mask),
    .unc_sev   (unc_sev),
    .cor_mask  (cor_mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_sev   <= SEV_COR;
      msg_src   <= '0;
      hdr_req   <= 1'b0;
      ovf_pend  <= 1'b0;
      ovf_src   <= '0;
      last_src  <= '0;
    end else begin
      msg_valid <= take && v.msg;
      hdr_req   <= take && v.hdr;
      if (take && v.msg) begin
        msg_sev <= v.sev;
        msg_src <= ovf_pend ? ovf_src : evt_src;
      end
      if (accept) last_src <= evt_src;
      if (hdr_req && hdr_overflow) begin
        ovf_pend <= 1'b1;
        ovf_src  <= last_src;
      end else if (ovf_pend) begin
        ovf_pend <= 1'b0;
      end
    end
  end

  assert_busy_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hdr_req && hdr_overflow));
  assert_overflow_is_correctable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && msg_valid) |-> msg_sev == SEV_COR);
  assert_no_hdr_from_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_req |-> !$past(busy));
  assert_reject_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept && v.reject) |-> (!msg_valid && !hdr_req));
  assert_sev_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_sev != 2'd3);
  assert_corr_class_sev_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(accept && evt_corr) && msg_valid) |-> msg_sev == SEV_COR);
endmodule

// File: tb/err_signal_unit_test.sv
module err_signal_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] T_COR_SUP = 32'h0000_F1C1;
  localparam logic [31:0] T_UNC_SUP = 32'h03FF_F030;
  localparam logic [31:0] T_FAT_DEF = 32'h0046_2030;

  logic clk = 0, rst_n = 0;
  logic evt_valid = 0, evt_corr = 0, evt_advisory = 0;
  logic [31:0] evt_status = 0;
  logic [15:0] evt_src = 0;
  logic reg_wr = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0;
  logic ctl_cor_en = 0, ctl_nonfatal_en = 0, ctl_fatal_en = 0, ctl_ur_en = 0, cmd_serr_en = 0;
  logic hdr_overflow = 0;
  logic evt_ready, msg_valid, hdr_req, busy;
  logic [1:0] msg_sev;
  logic [15:0] msg_src;
  logic [31:0] unc_status, cor_status;
  logic [3:0] dev_status;

  int checks = 0, fails = 0;
  logic [31:0] m_unc = 0, m_cor = 0, m_umask = 0, m_usev = T_FAT_DEF, m_cmask = 0;
  logic [3:0] m_dev = 0;
  logic e_rej, e_msg, e_hdr;
  logic [1:0] e_sev;
  logic [31:0] e_uset, e_cset;
  logic [3:0] e_dset;

  err_signal_unit uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog R9 act=hung exp=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // independent expectation from the requirement text
  task automatic predict(logic [31:0] st, logic corr, logic adv);
    logic [31:0] b;
    logic ur, fat;
    b = st & (corr ? T_COR_SUP : T_UNC_SUP);
    e_rej = 0; e_msg = 0; e_hdr = 0; e_sev = 0; e_uset = 0; e_cset = 0; e_dset = 0;
    if ($countones(b) != 1) begin e_rej = 1; return; end
    ur  = !corr && (b == 32'h0010_0000);
    fat = !corr && ((b & m_usev) != 0);
    if (corr) begin
      e_cset = b; e_dset = 4'b0001;
      if ((m_cmask & b) == 0) e_msg = ctl_cor_en;
      return;
    end
    if (!fat && adv) begin
      e_uset = b; e_cset = 32'h0000_2000; e_dset = {ur, 3'b001};
      if (m_cmask[13]) return;
      e_hdr = (b & m_umask) == 0;
      e_msg = ctl_cor_en && (!ur || ctl_ur_en);
      return;
    end
    e_uset = b;
    e_dset = {ur, fat, !fat, 1'b0};
    if ((b & m_umask) != 0) return;
    e_hdr = 1;
    e_sev = fat ? 2'd2 : 2'd1;
    if (ur && !ctl_ur_en && !cmd_serr_en) return;
    e_msg = cmd_serr_en || (fat ? ctl_fatal_en : ctl_nonfatal_en);
  endtask

  task automatic check_result(string tag, logic [15:0] src);
    chk({tag, " msg_valid"}, 32'(msg_valid), 32'(e_msg));
    if (e_msg) begin
      chk({tag, " msg_sev R9"}, 32'(msg_sev), 32'(e_sev));
      chk({tag, " msg_src"}, 32'(msg_src), 32'(src));
    end
    chk({tag, " hdr_req R5"}, 32'(hdr_req), 32'(e_hdr));
    m_unc |= e_uset; m_cor |= e_cset; m_dev |= e_dset;
    chk({tag, " unc_status R5"}, unc_status, m_unc);
    chk({tag, " cor_status R3"}, cor_status, m_cor);
    chk({tag, " dev_status R3"}, 32'(dev_status), 32'(m_dev));
  endtask

  task automatic send(logic [31:0] st, logic corr, logic adv, logic [15:0] src, logic ovf);
    string tag;
    logic want_ovf;
    @(negedge clk);
    chk("ready idle R8", 32'(evt_ready), 1);
    evt_valid = 1; evt_status = st; evt_corr = corr; evt_advisory = adv; evt_src = src;
    predict(st, corr, adv);
    tag = e_rej ? "R1" : corr ? "R4" : (adv && e_cset != 0) ? "R7" : "R6";
    @(negedge clk);
    evt_valid = 0;
    check_result(tag, src);
    want_ovf = e_hdr && ovf;
    hdr_overflow = ovf;
    @(negedge clk);
    hdr_overflow = 0;
    chk("pulse ends R9", 32'(msg_valid | hdr_req), 0);
    chk("busy R8", 32'(busy), 32'(want_ovf));
    chk("ready R8", 32'(evt_ready), 32'(!want_ovf));
    if (want_ovf) begin
      predict(32'h0000_8000, 1'b1, 1'b0);
      @(negedge clk);
      check_result("R8 overflow", src);
    end
  endtask

  task automatic wreg(logic [2:0] sel, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (sel)
      3'd0: m_unc &= ~d;
      3'd1: m_umask = d;
      3'd2: m_usev = d;
      3'd3: m_cor &= ~d;
      3'd4: m_cmask = d;
      3'd5: m_dev &= ~d[3:0];
      default: ;
    endcase
  endtask

  task automatic set_en(logic c, logic nf, logic f, logic u, logic s);
    ctl_cor_en = c; ctl_nonfatal_en = nf; ctl_fatal_en = f; ctl_ur_en = u; cmd_serr_en = s;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset unc R10", unc_status, 0);
    chk("reset cor R10", cor_status, 0);
    chk("reset dev R10", 32'(dev_status), 0);
    chk("reset msg R9", 32'(msg_valid | hdr_req | busy), 0);

    // R1: rejection cases
    set_en(1, 1, 1, 1, 1);
    send(32'h0, 0, 0, 16'h0101, 0);
    send(32'h0000_0030, 0, 0, 16'h0102, 0);
    send(32'h0000_0002, 1, 0, 16'h0103, 0);
    send(32'h0000_0001, 0, 0, 16'h0104, 0);
    // R2: default fatal for bit 4, non-fatal for bit 12, then override
    set_en(0, 1, 1, 0, 0);
    send(32'h0000_0010, 0, 0, 16'h0201, 0);
    send(32'h0000_1000, 0, 0, 16'h0202, 0);
    wreg(3'd2, 32'h0000_1000);
    send(32'h0000_1000, 0, 0, 16'h0203, 0);
    send(32'h0000_0010, 0, 0, 16'h0204, 0);
    wreg(3'd2, T_FAT_DEF);
    // R5: masked uncorrectable
    wreg(3'd1, 32'h0004_0000);
    send(32'h0004_0000, 0, 0, 16'h0301, 0);
    wreg(3'd1, 32'h0);
    // R6: UR drop and serr rescue
    set_en(1, 1, 1, 0, 0);
    send(32'h0010_0000, 0, 0, 16'h0401, 0);
    set_en(0, 0, 0, 0, 1);
    send(32'h0010_0000, 0, 0, 16'h0402, 0);
    // R7: advisory path, UR advisory without UR enable, masked advisory bit
    set_en(1, 0, 0, 0, 0);
    send(32'h0000_4000, 0, 1, 16'h0501, 0);
    send(32'h0010_0000, 0, 1, 16'h0502, 0);
    wreg(3'd4, 32'h0000_2000);
    send(32'h0000_8000, 0, 1, 16'h0503, 0);
    wreg(3'd4, 32'h0);
    send(32'h0000_0010, 0, 1, 16'h0504, 0);
    // R3/R4: correctable masked and unmasked
    wreg(3'd4, 32'h0000_0040);
    send(32'h0000_0040, 1, 0, 16'h0601, 0);
    send(32'h0000_0080, 1, 0, 16'h0602, 0);
    wreg(3'd4, 32'h0);
    // R8: overflow follow-on, and overflow ignored without hdr_req
    set_en(1, 1, 1, 1, 0);
    send(32'h0000_0020, 0, 0, 16'h0701, 1);
    send(32'h0000_0100, 1, 0, 16'h0702, 1);
    // R10: W1C clears
    wreg(3'd0, 32'hFFFF_FFFF);
    wreg(3'd3, 32'h0000_0040);
    wreg(3'd5, 32'h0000_0003);
    @(negedge clk);
    chk("w1c unc R10", unc_status, m_unc);
    chk("w1c cor R10", cor_status, m_cor);
    chk("w1c dev R10", 32'(dev_status), 32'(m_dev));

    for (int i = 0; i < 400; i++) begin
      logic [31:0] st;
      int k;
      set_en($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 4) == 0);
      k = $urandom % 8;
      if (k == 0) st = 0;
      else if (k == 1) st = (32'h1 << ($urandom % 32)) | (32'h1 << ($urandom % 32));
      else st = 32'h1 << ($urandom % 32);
      if ($urandom % 16 == 0) wreg(3'd1, $urandom & $urandom);
      if ($urandom % 16 == 0) wreg(3'd2, $urandom);
      if ($urandom % 16 == 0) wreg(3'd4, $urandom & $urandom);
      if ($urandom % 10 == 0) wreg(3'($urandom % 2 ? 0 : 3), $urandom);
      if ($urandom % 12 == 0) wreg(3'd5, $urandom);
      send(st, $urandom % 2, $urandom % 2, 16'($urandom), $urandom % 2);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule